// File: doc/BRIEF.md
# Per-Locality Interrupt Controller

This block keeps an interrupt-enable word and an interrupt-status word for each locality of a security co-processor's register interface. It drives a single interrupt request line that all localities share. The event sources pulse one event input per locality and per event kind: data available, status valid, locality change and command ready. Each pulse sets the matching status bit. Software clears status bits by writing ones to them. Software can also read the configured interrupt vector and a fixed capability word.

Only the locality that currently owns the interface may change its enable or status word. Writes from any other locality are dropped. The owner's enable word sets whether the line signals a high level, a low level, a rising edge or a falling edge. It also holds a global enable that gates the request.

Top module: `loc_irq_ctrl`

## Requirements
- R1: After reset every enable and status word reads 0 and the line is low.
- R2: An event pulse sets its status bit one clock later, even when the matching enable bit is clear. The event order in `evt` is data available, status valid, locality change, command ready, and these map to status bits 0, 1, 2 and 7.
- R3: Writing the status word clears each bit that is written as 1 within the mask 0x87. All other bits are left as they are.
- R4: If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R5: A write to the enable or status word of a locality that is not the owner is ignored. This also applies when no locality owns the interface.
- R6: The enable word keeps only bits 0, 1, 2, 3, 4, 7 and 31. All other bits read back as 0.
- R7: The request is raised when the owner's enable bit 31 is set and the owner's enable AND status is nonzero in bits 0, 1, 2 or 7.
- R8: Enable bits 4:3 select the trigger. With 0 (high level) the line follows the request. With 1 (low level) the line is the inverse of the request.
- R9: With 2 (rising edge) the line pulses high for one cycle each time the request rises. With 3 (falling edge) the line idles high and drops low for one cycle each time the request rises.
- R10: Register select 2 reads the configured vector and select 3 reads 0x20000697. Both are read-only.
- R11: Only the owner's request and trigger mode drive the line. When there is no owner, the line is low.
- R12: A read of a locality index at or above the locality count returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | A locality owns the interface |
| act_loc | input | LOC_W | Index of the owning locality |
| wr_en | input | 1 | Register write strobe |
| wr_loc | input | LOC_W | Locality addressed by the write |
| wr_sel | input | 2 | Write register select: 0 enable, 1 status, 2 vector, 3 capability |
| wr_data | input | 32 | Write data |
| evt | input | 4*NUM_LOC | Event pulses, four per locality, at [4*l+3:4*l] = {command ready, locality change, status valid, data available} |
| cfg_vec | input | VEC_W | Configured interrupt vector |
| rd_loc | input | LOC_W | Locality addressed by the read |
| rd_sel | input | 2 | Read register select, same encoding as wr_sel |
| rd_data | output | 32 | Read data, combinational |
| irq_o | output | 1 | Shaped interrupt request line |

## Verification
Writes and event pulses update the stored words at the next rising edge. Reads are combinational, so each write or event shows up on `rd_data` and in the level modes on `irq_o` within the same cycle after that edge. In the edge modes the pulse lasts exactly the one cycle after the edge at which the request became set, and the line returns to idle after the following edge.

The bench applies each stimulus on a falling edge. It compares the outputs on the next falling edge, which is one rising edge later. It then applies the next vector, which shows both the pulse cycle and the return to idle.

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl #(
  parameter int NUM_LOC = 5,
  parameter int VEC_W   = 8,
  parameter int LOC_W   = $clog2(NUM_LOC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_valid,
  input  logic [LOC_W-1:0]     act_loc,
  input  logic                 wr_en,
  input  logic [LOC_W-1:0]     wr_loc,
  input  logic [1:0]           wr_sel,
  input  logic [31:0]          wr_data,
  input  logic [4*NUM_LOC-1:0] evt,
  input  logic [VEC_W-1:0]     cfg_vec,
  input  logic [LOC_W-1:0]     rd_loc,
  input  logic [1:0]           rd_sel,
  output logic [31:0]          rd_data,
  output logic                 irq_o
);
  localparam logic [1:0]  SEL_EN   = 2'd0;
  localparam logic [1:0]  SEL_STS  = 2'd1;
  localparam logic [1:0]  SEL_VEC  = 2'd2;
  localparam logic [31:0] EN_MASK  = 32'h8000_009F;
  localparam logic [31:0] STS_MASK = 32'h0000_0087;
  localparam logic [31:0] CAP_WORD = 32'h2000_0697;

  logic [NUM_LOC-1:0][31:0] en_q, sts_q;
  logic [NUM_LOC-1:0]       own, pend;
  logic                     raw, raw_q, pulse;
  logic [1:0]               mode;

  for (genvar l = 0; l < NUM_LOC; l++) begin : g_loc
    logic        wr_hit;
    logic [31:0] set_bits, clr_bits;

    assign own[l]   = act_valid && (act_loc == LOC_W'(l));
    assign wr_hit   = wr_en && own[l] && (wr_loc == LOC_W'(l));
    assign set_bits = {24'b0, evt[4*l+3], 4'b0, evt[4*l+2], evt[4*l+1], evt[4*l]};
    assign clr_bits = (wr_hit && wr_sel == SEL_STS) ? (wr_data & STS_MASK) : 32'b0;
    assign pend[l]  = en_q[l][31] && |(en_q[l] & sts_q[l] & STS_MASK);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[l]  <= '0;
        sts_q[l] <= '0;
      end else begin
        if (wr_hit && wr_sel == SEL_EN) en_q[l] <= wr_data & EN_MASK;
        sts_q[l] <= (sts_q[l] & ~clr_bits) | set_bits;
      end
    end
  end

  always_comb begin
    raw  = 1'b0;
    mode = 2'd0;
    for (int l = 0; l < NUM_LOC; l++) begin
      if (own[l]) begin
        raw  = pend[l];
        mode = en_q[l][4:3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= raw;
  end

  assign pulse = raw & ~raw_q;

  always_comb begin
    case (mode)
      2'd0:    irq_o = raw;
      2'd1:    irq_o = ~raw;
      2'd2:    irq_o = pulse;
      default: irq_o = ~pulse;
    endcase
  end

  always_comb begin
    rd_data = '1;
    if (32'(rd_loc) < NUM_LOC) begin
      case (rd_sel)
        SEL_EN:  rd_data = en_q[rd_loc];
        SEL_STS: rd_data = sts_q[rd_loc];
        SEL_VEC: rd_data = 32'(cfg_vec);
        default: rd_data = CAP_WORD;
      endcase
    end
  end
endmodule

// File: rtl/loc_irq_ctrl_chk.sv
module loc_irq_ctrl_chk #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     act_valid,
  input logic [LOC_W-1:0]         act_loc,
  input logic                     wr_en,
  input logic [LOC_W-1:0]         wr_loc,
  input logic [1:0]               wr_sel,
  input logic [31:0]              wr_data,
  input logic [4*NUM_LOC-1:0]     evt,
  input logic [LOC_W-1:0]         rd_loc,
  input logic [1:0]               rd_sel,
  input logic [31:0]              rd_data,
  input logic                     irq_o,
  input logic [NUM_LOC-1:0][31:0] en_q,
  input logic [NUM_LOC-1:0][31:0] sts_q
);
  logic rise_m;

  always_comb begin
    rise_m = 1'b0;
    for (int l = 0; l < NUM_LOC; l++)
      if (act_valid && 32'(act_loc) == l && en_q[l][4:3] == 2'd2) rise_m = 1'b1;
  end

  for (genvar l = 0; l < NUM_LOC; l++) begin : g_chk
    // R2 and R4: a pulsed event always leaves its bit set
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[4*l] |=> sts_q[l][0]);
    p_cmd_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt[4*l+3] |=> sts_q[l][7]);
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && 32'(wr_loc) == l && act_valid && 32'(act_loc) == l
       && wr_data[1] && !evt[4*l+1]) |=> !sts_q[l][1]);
    p_foreign_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0 && 32'(wr_loc) == l && !(act_valid && 32'(act_loc) == l))
      |=> $stable(en_q[l]));
    p_foreign_sts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && 32'(wr_loc) == l && !(act_valid && 32'(act_loc) == l)
       && evt[4*l+3:4*l] == 4'b0) |=> $stable(sts_q[l]));
  end

  p_rise_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_m && irq_o) |=> !(rise_m && irq_o));
  p_no_owner_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid |-> !irq_o);
  p_cap_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd3 && 32'(rd_loc) < NUM_LOC) |-> rd_data == 32'h2000_0697);
  p_oob_ones_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_loc) >= NUM_LOC) |-> rd_data == 32'hFFFF_FFFF);
endmodule

bind loc_irq_ctrl loc_irq_ctrl_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_loc(act_loc),
  .wr_en(wr_en), .wr_loc(wr_loc), .wr_sel(wr_sel), .wr_data(wr_data),
  .evt(evt), .rd_loc(rd_loc), .rd_sel(rd_sel), .rd_data(rd_data),
  .irq_o(irq_o), .en_q(en_q), .sts_q(sts_q)
);

// File: tb/test_loc_irq_ctrl.sv
`timescale 1ns/1ps
module test_loc_irq_ctrl;
  localparam int NUM_LOC = 5;
  localparam int LOC_W   = 3;
  localparam int VEC_W   = 8;

  typedef struct packed {
    logic        av;
    logic [2:0]  al;
    logic        we;
    logic [2:0]  wl;
    logic [1:0]  ws;
    logic [31:0] wd;
    logic [19:0] ev;
    logic [2:0]  rl;
    logic [1:0]  rs;
    logic [31:0] xr;
    logic        xi;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{1'b1,3'd1,1'b0,3'd0,2'd0,32'h0,20'h0,3'd1,2'd0,32'h0,1'b0,8'd1},                  // R1
    '{1'b1,3'd1,1'b0,3'd0,2'd0,32'h0,20'h0,3'd1,2'd1,32'h0,1'b0,8'd1},                  // R1
    '{1'b1,3'd1,1'b0,3'd0,2'd0,32'h0,20'h10,3'd1,2'd1,32'h1,1'b0,8'd2},                 // R2
    '{1'b1,3'd1,1'b0,3'd0,2'd0,32'h0,20'h80,3'd1,2'd1,32'h81,1'b0,8'd2},                // R2
    '{1'b1,3'd1,1'b1,3'd1,2'd0,32'hFFFFFF60,20'h0,3'd1,2'd0,32'h80000000,1'b0,8'd6},    // R6
    '{1'b1,3'd1,1'b1,3'd1,2'd0,32'h80000001,20'h0,3'd1,2'd1,32'h81,1'b1,8'd7},          // R7
    '{1'b1,3'd1,1'b1,3'd1,2'd1,32'h1,20'h0,3'd1,2'd1,32'h80,1'b0,8'd3},                 // R3
    '{1'b1,3'd1,1'b1,3'd1,2'd1,32'h1,20'h10,3'd1,2'd1,32'h81,1'b1,8'd4},                // R4
    '{1'b1,3'd1,1'b1,3'd1,2'd1,32'hFFFFFFFF,20'h0,3'd1,2'd1,32'h0,1'b0,8'd3},           // R3
    '{1'b1,3'd1,1'b1,3'd2,2'd0,32'h80000087,20'h0,3'd2,2'd0,32'h0,1'b0,8'd5},           // R5
    '{1'b1,3'd1,1'b0,3'd0,2'd0,32'h0,20'h100,3'd2,2'd1,32'h1,1'b0,8'd11},               // R11
    '{1'b1,3'd1,1'b1,3'd2,2'd1,32'h1,20'h0,3'd2,2'd1,32'h1,1'b0,8'd5},                  // R5
    '{1'b1,3'd1,1'b0,3'd0,2'd0,32'h0,20'h20,3'd1,2'd1,32'h2,1'b0,8'd7},                 // R7
    '{1'b1,3'd1,1'b1,3'd1,2'd0,32'h2,20'h0,3'd1,2'd0,32'h2,1'b0,8'd7},                  // R7
    '{1'b1,3'd1,1'b1,3'd1,2'd0,32'h8000000A,20'h0,3'd1,2'd0,32'h8000000A,1'b0,8'd8},    // R8
    '{1'b1,3'd1,1'b1,3'd1,2'd1,32'h2,20'h0,3'd1,2'd1,32'h0,1'b1,8'd8},                  // R8
    '{1'b1,3'd1,1'b1,3'd1,2'd0,32'h80000012,20'h0,3'd1,2'd0,32'h80000012,1'b0,8'd9},    // R9
    '{1'b1,3'd1,1'b0,3'd0,2'd0,32'h0,20'h20,3'd1,2'd1,32'h2,1'b1,8'd9},                 // R9
    '{1'b1,3'd1,1'b0,3'd0,2'd0,32'h0,20'h0,3'd1,2'd1,32'h2,1'b0,8'd9},                  // R9
    '{1'b1,3'd1,1'b1,3'd1,2'd0,32'h8000001A,20'h0,3'd1,2'd0,32'h8000001A,1'b1,8'd9},    // R9
    '{1'b1,3'd1,1'b1,3'd1,2'd1,32'h2,20'h0,3'd1,2'd1,32'h0,1'b1,8'd9},                  // R9
    '{1'b1,3'd1,1'b0,3'd0,2'd0,32'h0,20'h20,3'd1,2'd1,32'h2,1'b0,8'd9},                 // R9
    '{1'b1,3'd1,1'b0,3'd0,2'd0,32'h0,20'h0,3'd1,2'd1,32'h2,1'b1,8'd9},                  // R9
    '{1'b1,3'd1,1'b1,3'd1,2'd2,32'h55,20'h0,3'd0,2'd2,32'hA,1'b1,8'd10},                // R10
    '{1'b1,3'd1,1'b1,3'd1,2'd3,32'h0,20'h0,3'd3,2'd3,32'h20000697,1'b1,8'd10},          // R10
    '{1'b1,3'd1,1'b0,3'd0,2'd0,32'h0,20'h0,3'd6,2'd0,32'hFFFFFFFF,1'b1,8'd12},          // R12
    '{1'b0,3'd1,1'b0,3'd0,2'd0,32'h0,20'h0,3'd1,2'd1,32'h2,1'b0,8'd11},                 // R11
    '{1'b0,3'd1,1'b1,3'd1,2'd0,32'h0,20'h0,3'd1,2'd0,32'h8000001A,1'b0,8'd5},           // R5
    '{1'b1,3'd2,1'b0,3'd0,2'd0,32'h0,20'h0,3'd2,2'd1,32'h1,1'b0,8'd11},                 // R11
    '{1'b1,3'd2,1'b1,3'd2,2'd0,32'h80000001,20'h0,3'd2,2'd0,32'h80000001,1'b1,8'd11}    // R11
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 act_valid = 1'b0;
  logic [LOC_W-1:0]     act_loc = '0;
  logic                 wr_en = 1'b0;
  logic [LOC_W-1:0]     wr_loc = '0;
  logic [1:0]           wr_sel = '0;
  logic [31:0]          wr_data = '0;
  logic [4*NUM_LOC-1:0] evt = '0;
  logic [VEC_W-1:0]     cfg_vec = 8'h0A;
  logic [LOC_W-1:0]     rd_loc = '0;
  logic [1:0]           rd_sel = '0;
  logic [31:0]          rd_data;
  logic                 irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  loc_irq_ctrl #(.NUM_LOC(NUM_LOC), .VEC_W(VEC_W), .LOC_W(LOC_W)) i_loc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_loc(act_loc),
    .wr_en(wr_en), .wr_loc(wr_loc), .wr_sel(wr_sel), .wr_data(wr_data),
    .evt(evt), .cfg_vec(cfg_vec), .rd_loc(rd_loc), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0;
    evt   = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    act_valid = 1'b1; act_loc = 3'd1;
    // R1: state during reset
    rd_loc = 3'd3; rd_sel = 2'd0;
    check("R1 reset enable", rd_data, 32'h0);
    check("R1 reset line", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      act_valid = TBL[i].av; act_loc = TBL[i].al;
      wr_en = TBL[i].we; wr_loc = TBL[i].wl; wr_sel = TBL[i].ws; wr_data = TBL[i].wd;
      evt = TBL[i].ev; rd_loc = TBL[i].rl; rd_sel = TBL[i].rs;
      @(negedge clk);
      check($sformatf("R%0d vec%0d read", TBL[i].rq, i), rd_data, TBL[i].xr);
      check($sformatf("R%0d vec%0d line", TBL[i].rq, i), {31'b0, irq_o}, {31'b0, TBL[i].xi});
      idle_inputs();
    end

    // R4: command-ready event beats a clear in the same cycle
    act_valid = 1'b1; act_loc = 3'd2;
    wr_en = 1'b1; wr_loc = 3'd2; wr_sel = 2'd1; wr_data = 32'h80; evt = 20'h800;
    rd_loc = 3'd2; rd_sel = 2'd1;
    @(negedge clk);
    check("R4 cmd set wins", rd_data, 32'h81);
    idle_inputs();

    // R3: clearing the command-ready bit alone
    wr_en = 1'b1; wr_loc = 3'd2; wr_sel = 2'd1; wr_data = 32'h80;
    @(negedge clk);
    check("R3 clear bit7", rd_data, 32'h1);
    idle_inputs();

    // R1: reset in the middle of a run clears state and line
    rst_n = 1'b0;
    @(negedge clk);
    rd_loc = 3'd2; rd_sel = 2'd1;
    check("R1 mid reset status", rd_data, 32'h0);
    rd_sel = 2'd0;
    check("R1 mid reset enable", rd_data, 32'h0);
    rd_loc = 3'd1;
    check("R1 mid reset other enable", rd_data, 32'h0);
    check("R1 mid reset line", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule